// File: doc/BRIEF.md
# Page-Buffered Memory Programming Controller

This block carries out already-decoded programming commands on two internal arrays: a program memory organised as 16-bit words and a data memory organised as bytes. Program memory is written a page at a time. Bytes are first collected in a small page buffer, and a commit command then writes the whole page to the array. The upper part of the page number comes from an extension register that keeps its value between commands. Data memory is written one byte at a time. Every write is self-timed: it first erases its target to all ones, and only at the end of a fixed busy window does it place the new content.

Commands arrive on a parallel strobe: `cmd_valid`, an opcode, an address and a data byte. The block has no ready signal. Reads and the busy poll answer one cycle later on `rsp_valid`/`rsp_data`. A command that would modify state while a write is running is dropped and marked with a one-cycle `refused` pulse. A high byte loaded for a word whose low byte has not yet been loaded is dropped and marked with `order_err`.

Top module: `pgm_ctrl`

## Requirements
- R1: After reset, `busy`, `rsp_valid`, `refused` and `order_err` are 0, the extension register is 0, and every program-memory word and data-memory byte reads as 0xFF.
- R2: Load-low (op 2) and load-high (op 3) place `cmd_data` into the low or high byte of page-buffer word `cmd_addr[PG_W-1:0]`. The upper address bits have no effect on where the byte goes.
- R3: A load-high for a buffer word whose low byte has not been loaded since the last commit is dropped, and `order_err` is 1 in the following cycle. That word's high byte stays 0xFF in the committed page.
- R4: Page write (op 4) selects page number {extension, `cmd_addr[ADDR_W-1:PG_W]`}. While busy, every word of that page reads 0xFFFF. After busy falls, the page holds the buffer contents.
- R5: Load-extension (op 1) sets the extension register to `cmd_data[EXT_W-1:0]`. Only another accepted op 1 changes it. Program reads use word address {extension, `cmd_addr`}.
- R6: After each page commit, every buffer byte returns to 0xFF and every low-loaded mark is cleared.
- R7: Data write (op 5) erases byte `cmd_addr[DM_AW-1:0]` to 0xFF when accepted, and stores `cmd_data` there when busy falls.
- R8: Chip erase (op 10) sets every program-memory and data-memory location to 0xFF.
- R9: An accepted op 4, 5 or 10 raises `busy` in the next cycle and holds it for exactly WR_CYC cycles.
- R10: While `busy` is 1, ops 1, 2, 3, 4, 5 and 10 change no state, and `refused` is 1 in the following cycle.
- R11: Read-low (op 6), read-high (op 7) and read-data (op 8) set `rsp_valid` in the following cycle. `rsp_data` then holds the addressed byte, including while busy.
- R12: Poll (op 9) returns `rsp_data` = 1 if `busy` was 1 when the poll was issued, and 0 otherwise. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Opcode (see requirements) |
| cmd_addr | input | ADDR_W | Command address |
| cmd_data | input | 8 | Command data byte |
| busy | output | 1 | Self-timed write in progress |
| rsp_valid | output | 1 | Read or poll response valid |
| rsp_data | output | 8 | Response byte |
| refused | output | 1 | Previous command dropped because busy |
| order_err | output | 1 | Previous high-byte load dropped, low byte missing |

## Verification
The assertions check on every cycle that the busy window is exactly WR_CYC cycles long and starts only after a write-class command. They also check that `refused` and `order_err` follow only the commands that may cause them, and that a poll reports the busy state it saw. What only the bench scenarios can show is memory content: the erase-then-write sequence seen through reads inside the busy window, the page chosen by the extension register, buffer clearing after a commit, and the dropping of refused or out-of-order bytes. The bench does this with full sweeps of every page and every data byte in a small configuration.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_LOAD_EXT   = 4'd1,
        OP_LOAD_LO    = 4'd2,
        OP_LOAD_HI    = 4'd3,
        OP_WRITE_PAGE = 4'd4,
        OP_WRITE_DATA = 4'd5,
        OP_READ_LO    = 4'd6,
        OP_READ_HI    = 4'd7,
        OP_READ_DATA  = 4'd8,
        OP_POLL       = 4'd9,
        OP_ERASE      = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_PAGE,
        PEND_DATA,
        PEND_ERASE
    } pend_e;

    localparam logic [7:0]  BYTE_ERASED = 8'hFF;
    localparam logic [15:0] WORD_ERASED = 16'hFFFF;

    function automatic logic op_mutates(input logic [3:0] op);
        case (op)
            OP_LOAD_EXT, OP_LOAD_LO, OP_LOAD_HI,
            OP_WRITE_PAGE, OP_WRITE_DATA, OP_ERASE: op_mutates = 1'b1;
            default:                                op_mutates = 1'b0;
        endcase
    endfunction

    function automatic logic op_timed(input logic [3:0] op);
        op_timed = (op == OP_WRITE_PAGE) || (op == OP_WRITE_DATA) || (op == OP_ERASE);
    endfunction

    function automatic logic op_answers(input logic [3:0] op);
        op_answers = (op == OP_READ_LO) || (op == OP_READ_HI) ||
                     (op == OP_READ_DATA) || (op == OP_POLL);
    endfunction

endpackage

// File: rtl/pgm_timer.sv
module pgm_timer #(
    parameter int WR_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WR_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(WR_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/pgm_pagebuf.sv
module pgm_pagebuf #(
    parameter int PG_W = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        lo_we,
    input  logic                        hi_we,
    input  logic [PG_W-1:0]             idx,
    input  logic [7:0]                  wdata,
    input  logic                        clear,
    output logic [(1<<PG_W)-1:0][15:0]  words,
    output logic [(1<<PG_W)-1:0]        lo_ok
);
    import pgm_pkg::*;
    localparam int PAGE = 1 << PG_W;

    for (genvar g = 0; g < PAGE; g++) begin : g_word
        logic [15:0] word_q;
        logic        mark_q;
        logic        hit;
        assign hit = (idx == PG_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                word_q <= WORD_ERASED;
                mark_q <= 1'b0;
            end else begin
                if (lo_we && hit) begin
                    word_q[7:0] <= wdata;
                    mark_q      <= 1'b1;
                end
                if (hi_we && hit && mark_q)
                    word_q[15:8] <= wdata;
            end
        end

        assign words[g] = word_q;
        assign lo_ok[g] = mark_q;
    end
endmodule

// File: rtl/pgm_ctrl.sv
module pgm_ctrl #(
    parameter int ADDR_W = 5,
    parameter int EXT_W  = 2,
    parameter int PG_W   = 2,
    parameter int DM_AW  = 4,
    parameter int WR_CYC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output logic              busy,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              refused,
    output logic              order_err
);
    import pgm_pkg::*;

    localparam int PAGE  = 1 << PG_W;
    localparam int PM_AW = EXT_W + ADDR_W;
    localparam int PN_W  = PM_AW - PG_W;
    localparam int PM_D  = 1 << PM_AW;
    localparam int DM_D  = 1 << DM_AW;

    typedef struct packed {
        pend_e             kind;
        logic [PN_W-1:0]   page;
        logic [DM_AW-1:0]  daddr;
        logic [7:0]        data;
    } pend_t;

    logic [15:0]      pm [PM_D];
    logic [7:0]       dm [DM_D];
    logic [EXT_W-1:0] ext_q;
    pend_t            pend_q;

    op_e              op;
    logic             acc;
    logic             timer_done;
    logic             buf_clear;
    logic [PAGE-1:0][15:0] buf_words;
    logic [PAGE-1:0]  buf_lo_ok;
    logic [PG_W-1:0]  widx;
    logic [PN_W-1:0]  cmd_page;
    logic [PM_AW-1:0] rd_idx;
    logic [DM_AW-1:0] dm_idx;
    logic [7:0]       rsp_next;
    logic             rsp_valid_q, refused_q, order_err_q;
    logic [7:0]       rsp_data_q;

    assign op       = op_e'(cmd_op);
    assign acc      = cmd_valid && !busy && op_mutates(cmd_op);
    assign widx     = cmd_addr[PG_W-1:0];
    assign cmd_page = {ext_q, cmd_addr[ADDR_W-1:PG_W]};
    assign rd_idx   = {ext_q, cmd_addr};
    assign dm_idx   = cmd_addr[DM_AW-1:0];
    assign buf_clear = timer_done && (pend_q.kind == PEND_PAGE);

    pgm_timer #(.WR_CYC(WR_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (acc && op_timed(cmd_op)),
        .busy  (busy),
        .done  (timer_done)
    );

    pgm_pagebuf #(.PG_W(PG_W)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .lo_we (acc && op == OP_LOAD_LO),
        .hi_we (acc && op == OP_LOAD_HI),
        .idx   (widx),
        .wdata (cmd_data),
        .clear (buf_clear),
        .words (buf_words),
        .lo_ok (buf_lo_ok)
    );

    // Erase phase happens at acceptance, write phase when the timer expires.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PM_D; i++) pm[i] <= WORD_ERASED;
            for (int i = 0; i < DM_D; i++) dm[i] <= BYTE_ERASED;
            ext_q  <= '0;
            pend_q <= '0;
        end else begin
            if (acc) begin
                case (op)
                    OP_LOAD_EXT: ext_q <= cmd_data[EXT_W-1:0];
                    OP_WRITE_PAGE: begin
                        for (int w = 0; w < PAGE; w++)
                            pm[{cmd_page, PG_W'(w)}] <= WORD_ERASED;
                        pend_q.kind <= PEND_PAGE;
                        pend_q.page <= cmd_page;
                    end
                    OP_WRITE_DATA: begin
                        dm[dm_idx]   <= BYTE_ERASED;
                        pend_q.kind  <= PEND_DATA;
                        pend_q.daddr <= dm_idx;
                        pend_q.data  <= cmd_data;
                    end
                    OP_ERASE: begin
                        for (int i = 0; i < PM_D; i++) pm[i] <= WORD_ERASED;
                        for (int i = 0; i < DM_D; i++) dm[i] <= BYTE_ERASED;
                        pend_q.kind <= PEND_ERASE;
                    end
                    default: ;
                endcase
            end
            if (timer_done) begin
                case (pend_q.kind)
                    PEND_PAGE:
                        for (int w = 0; w < PAGE; w++)
                            pm[{pend_q.page, PG_W'(w)}] <= buf_words[w];
                    PEND_DATA: dm[pend_q.daddr] <= pend_q.data;
                    default: ;
                endcase
                pend_q.kind <= PEND_NONE;
            end
        end
    end

    always_comb begin
        case (op)
            OP_READ_LO:   rsp_next = pm[rd_idx][7:0];
            OP_READ_HI:   rsp_next = pm[rd_idx][15:8];
            OP_READ_DATA: rsp_next = dm[dm_idx];
            OP_POLL:      rsp_next = {7'd0, busy};
            default:      rsp_next = 8'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= 8'd0;
            refused_q   <= 1'b0;
            order_err_q <= 1'b0;
        end else begin
            rsp_valid_q <= cmd_valid && op_answers(cmd_op);
            if (cmd_valid && op_answers(cmd_op))
                rsp_data_q <= rsp_next;
            refused_q   <= cmd_valid && busy && op_mutates(cmd_op);
            order_err_q <= acc && (op == OP_LOAD_HI) && !buf_lo_ok[widx];
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign refused   = refused_q;
    assign order_err = order_err_q;
endmodule

// File: rtl/pgm_ctrl_chk.sv
module pgm_ctrl_chk #(
    parameter int WR_CYC = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       busy,
    input logic       rsp_valid,
    input logic [7:0] rsp_data,
    input logic       refused,
    input logic       order_err
);
    import pgm_pkg::*;
    localparam int RW = $clog2(WR_CYC + 2);

    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid) && op_timed($past(cmd_op)));

    assert_busy_bound_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> run_q < RW'(WR_CYC));

    assert_busy_length_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_q == RW'(WR_CYC));

    assert_refuse_cause_R10: assert property (@(posedge clk) disable iff (rst)
        refused |-> $past(busy) && $past(cmd_valid) && op_mutates($past(cmd_op)));

    assert_order_cause_R3: assert property (@(posedge clk) disable iff (rst)
        order_err |-> $past(cmd_valid) && !$past(busy) && $past(cmd_op) == OP_LOAD_HI);

    assert_rsp_cause_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_valid) && op_answers($past(cmd_op)));

    assert_poll_value_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(cmd_op) == OP_POLL |-> rsp_data == {7'd0, $past(busy)});
endmodule

bind pgm_ctrl pgm_ctrl_chk #(.WR_CYC(WR_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .refused   (refused),
    .order_err (order_err)
);

// File: tb/test_pgm_ctrl.sv
module test_pgm_ctrl;
    localparam int ADDR_W = 5, EXT_W = 2, PG_W = 2, DM_AW = 4, WR_CYC = 6;
    localparam int PAGES_PER_EXT = 1 << (ADDR_W - PG_W);

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0] cmd_data = 8'd0;
    logic busy, rsp_valid, refused, order_err;
    logic [7:0] rsp_data;
    int checks = 0, errors = 0;
    logic [15:0] pm_m [1 << (EXT_W + ADDR_W)];

    always #2 clk = ~clk;

    pgm_ctrl #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .PG_W(PG_W), .DM_AW(DM_AW), .WR_CYC(WR_CYC))
    i_pgm_ctrl (.clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
                .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy),
                .rsp_valid(rsp_valid), .rsp_data(rsp_data), .refused(refused),
                .order_err(order_err));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 4'd0;
    endtask

    task automatic rd(input string req, input logic [3:0] op, input logic [ADDR_W-1:0] a,
                      input logic [7:0] exp);
        issue(op, a, 8'h00);
        chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk(req, 32'(rsp_data), 32'(exp));
    endtask

    task automatic rd_word(input string req, input logic [ADDR_W-1:0] a, input logic [15:0] exp);
        rd(req, 4'd6, a, exp[7:0]);
        rd(req, 4'd7, a, exp[15:8]);
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    function automatic logic [7:0] lo_of(input int e, input int p, input int w);
        return 8'(e * 37 + p * 11 + w * 3 + 1);
    endfunction
    function automatic logic [7:0] hi_of(input int e, input int p, input int w);
        return 8'(lo_of(e, p, w) * 5) ^ 8'h96;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 refused", 32'(refused), 0);
        chk("R1 order_err", 32'(order_err), 0);
        for (int a = 0; a < 32; a++) rd_word("R1 pm", 5'(a), 16'hFFFF);
        for (int a = 0; a < 16; a++) rd("R1 dm", 4'd8, 5'(a), 8'hFF);
        issue(4'd0, 5'd0, 8'd0);
        chk("R12 nop", 32'(rsp_valid), 0);
        rd("R12 poll ready", 4'd9, 5'd0, 8'd0);

        // R3 high byte before low byte
        issue(4'd1, 5'd0, 8'd1);
        issue(4'd3, 5'd1, 8'hB1);
        chk("R3 order_err", 32'(order_err), 1);
        // R2 loads with garbage upper address bits
        issue(4'd2, {3'b101, 2'd0}, 8'h10);
        chk("R3 no err", 32'(order_err), 0);
        issue(4'd3, {3'b010, 2'd0}, 8'h20);
        chk("R2 hi ok", 32'(order_err), 0);
        issue(4'd2, {3'b111, 2'd1}, 8'h11);
        issue(4'd2, {3'b001, 2'd2}, 8'h12);
        issue(4'd3, {3'b100, 2'd2}, 8'h22);
        issue(4'd2, {3'b011, 2'd3}, 8'h13);
        issue(4'd3, {3'b110, 2'd3}, 8'h23);
        issue(4'd4, {3'd3, 2'b10}, 8'h00);
        chk("R9 busy raised", 32'(busy), 1);
        rd("R4 erased during busy", 4'd6, {3'd3, 2'd0}, 8'hFF);
        rd("R12 poll busy", 4'd9, 5'd0, 8'd1);
        issue(4'd1, 5'd0, 8'd3);
        chk("R10 ext refused", 32'(refused), 1);
        issue(4'd5, 5'd3, 8'h77);
        chk("R10 data refused", 32'(refused), 1);
        issue(4'd2, {3'd0, 2'd1}, 8'h55);
        chk("R10 load refused", 32'(refused), 1);
        wait_ready();
        rd("R12 poll after", 4'd9, 5'd0, 8'd0);
        rd_word("R4 w0", {3'd3, 2'd0}, 16'h2010);
        rd_word("R3 w1 hi dropped", {3'd3, 2'd1}, 16'hFF11);
        rd_word("R4 w2", {3'd3, 2'd2}, 16'h2212);
        rd_word("R4 w3", {3'd3, 2'd3}, 16'h2313);
        rd("R10 dm untouched", 4'd8, 5'd3, 8'hFF);
        // R6 buffer cleared by commit
        issue(4'd4, {3'd3, 2'b00}, 8'h00);
        wait_ready();
        for (int w = 0; w < 4; w++) rd_word("R6 cleared buffer", {3'd3, 2'(w)}, 16'hFFFF);
        issue(4'd3, 5'd0, 8'h44);
        chk("R6 marks cleared", 32'(order_err), 1);

        // R7 data writes, R9 busy length
        issue(4'd5, 5'd5, 8'h3C);
        begin
            int n = 0;
            while (busy) begin n++; @(negedge clk); end
            chk("R9 busy length", 32'(n), 32'(WR_CYC));
        end
        rd("R7 after", 4'd8, 5'd5, 8'h3C);
        issue(4'd5, 5'd5, 8'h81);
        rd("R7 erased during busy", 4'd8, 5'd5, 8'hFF);
        wait_ready();
        rd("R7 rewritten", 4'd8, 5'd5, 8'h81);
        for (int a = 0; a < 16; a++) begin
            issue(4'd5, 5'(a), 8'(a * 29 + 7));
            wait_ready();
        end
        for (int a = 0; a < 16; a++) rd("R7 sweep", 4'd8, {1'b1, 4'(a)}, 8'(a * 29 + 7));

        // R2/R4/R5 sweep of every page under every extension value
        for (int e = 0; e < 4; e++) begin
            issue(4'd1, 5'd0, 8'(e | 8'hF0));
            for (int p = 0; p < PAGES_PER_EXT; p++) begin
                for (int w = 0; w < 4; w++) begin
                    issue(4'd2, {3'(p ^ 5), 2'(w)}, lo_of(e, p, w));
                    issue(4'd3, {3'(p + w), 2'(w)}, hi_of(e, p, w));
                    pm_m[{2'(e), 3'(p), 2'(w)}] = {hi_of(e, p, w), lo_of(e, p, w)};
                end
                issue(4'd4, {3'(p), 2'(p)}, 8'h00);
                wait_ready();
            end
        end
        for (int e = 0; e < 4; e++) begin
            issue(4'd1, 5'd0, 8'(e));
            for (int a = 0; a < 32; a++) rd_word("R5 page sweep", 5'(a), pm_m[{2'(e), 5'(a)}]);
        end

        // R8 chip erase
        issue(4'd10, 5'd0, 8'h00);
        chk("R9 erase busy", 32'(busy), 1);
        wait_ready();
        for (int e = 0; e < 4; e++) begin
            issue(4'd1, 5'd0, 8'(e));
            for (int a = 0; a < 32; a++) rd_word("R8 pm erased", 5'(a), 16'hFFFF);
        end
        for (int a = 0; a < 16; a++) rd("R8 dm erased", 4'd8, 5'(a), 8'hFF);
        rd("R11 read idle", 4'd6, 5'd0, 8'hFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule